// File: doc/BRIEF.md
# Video Resolution Change Notifier

This block sits behind a video timing measurement unit. It receives the measured horizontal active width, vertical active height and frame period of the incoming video, together with a flag that says whether an input signal is present and a strobe that marks each new frame measurement. From these it drives a single status pin. A static mode input chooses what the pin means.

In camera mode (mode input 0), the pin gives a host an interrupt. Each time the input settles on a new timing, the pin goes high for exactly 200 ms, so the host knows it must read the new resolution. In display mode (mode input 1), the pin is a level. It is high while a settled input is present and low otherwise, so a panel controller can use it to order panel power-up and power-down.

A timing counts as settled only after a programmable number of consecutive frames report the same values. This filters out glitches in the measurements. The pulse length is derived from a clock-frequency parameter through a millisecond prescaler.

Top module: `res_change_notifier`

## Requirements
- R1: While `rst` is high at a rising edge, the pin goes low in the next cycle. All counters, the candidate timing and the reference timing are cleared.
- R2: In camera mode, a detected change makes the pin high for exactly CLK_HZ/5 clock cycles (200 ms). CLK_HZ must be a multiple of 1000. The pin rises in the second cycle after the edge that samples the deciding frame strobe.
- R3: A timing is settled once `stable_frames` consecutive strobes, sampled while `sig_valid` is high, carry identical values on all three fields. A value of 0 in `stable_frames` behaves as 1.
- R4: The first settled timing after reset, or after `sig_valid` has been low, counts as a change. This holds even when the values equal the ones seen before.
- R5: Further strobes that repeat the reference timing produce no new pulse.
- R6: A change detected while a pulse is running restarts the full 200 ms count from the new change. The pin stays high in between, so it gives one longer pulse and not two.
- R7: In display mode, the pin goes high in the cycle after the edge at which the timing becomes settled.
- R8: In display mode, the pin goes low in the cycle after an edge that sees `sig_valid` low. It also goes low after a valid strobe that breaks the run of identical values, until the new values are settled.
- R9: A frame strobe seen while `sig_valid` is low has no effect on the pin.
- R10: `mode_display` picks the pin function: 1 selects the settled-input level, and 0 selects the change pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_display | input | 1 | Static mode: 1 = settled-input level, 0 = change pulse |
| sig_valid | input | 1 | An input video signal is present |
| frame_strobe | input | 1 | One-cycle marker: the timing fields hold a new measurement |
| h_active | input | 12 | Measured horizontal active pixels |
| v_active | input | 12 | Measured vertical active lines |
| frame_period | input | 20 | Measured frame period |
| stable_frames | input | CNT_W | Consecutive identical frames required before a timing is settled |
| status_pin | output | 1 | Notification pin |

## Verification
A frame strobe is sampled at a rising edge. In display mode, the level follows in the cycle right after that edge. In camera mode, the filter first registers a change flag and the timer then starts, so the pulse begins one cycle later and lasts CLK_HZ/5 cycles. A loss of `sig_valid` pulls the display level down after a single edge. The bench keeps a frame-history model built on queues and a countdown pulse model, both updated at each rising edge. It compares the pin with the model at every falling edge, so each result is checked in exactly the cycle it is due. It also measures one pulse end to end against the expected length.

// File: rtl/rcn_pkg.sv
package rcn_pkg;

    localparam int H_W      = 12;
    localparam int V_W      = 12;
    localparam int P_W      = 20;
    localparam int PULSE_MS = 200;

    typedef struct packed {
        logic [H_W-1:0] h_act;
        logic [V_W-1:0] v_act;
        logic [P_W-1:0] period;
    } vid_timing_t;

    typedef enum logic {
        PIN_CAMERA  = 1'b0,
        PIN_DISPLAY = 1'b1
    } pin_mode_e;

    function automatic logic timing_equal(input vid_timing_t a, input vid_timing_t b);
        return (a.h_act == b.h_act) && (a.v_act == b.v_act) && (a.period == b.period);
    endfunction

    function automatic int unsigned pulse_cycles(input int unsigned hz);
        return (hz / 1000) * PULSE_MS;
    endfunction

endpackage

// File: rtl/rcn_stability_filter.sv
module rcn_stability_filter
    import rcn_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_valid,
    input  logic             frame_strobe,
    input  vid_timing_t      sample,
    input  logic [CNT_W-1:0] need_frames,
    output logic             locked_o,
    output logic             change_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    vid_timing_t      cand_q;
    vid_timing_t      ref_q;
    logic             cand_vld_q;
    logic             ref_vld_q;
    logic [CNT_W-1:0] run_cnt_q;
    logic             locked_q;
    logic             change_q;

    logic [CNT_W-1:0] need_eff;
    logic             same_as_cand;
    logic [CNT_W-1:0] cnt_next;
    logic             stable_now;
    logic             new_change;

    always_comb begin
        need_eff     = (need_frames == '0) ? CNT_ONE : need_frames;
        same_as_cand = cand_vld_q && timing_equal(sample, cand_q);
        if (same_as_cand)
            cnt_next = (run_cnt_q == CNT_MAX) ? CNT_MAX : run_cnt_q + CNT_ONE;
        else
            cnt_next = CNT_ONE;
        stable_now = (cnt_next >= need_eff);
        new_change = stable_now && (!ref_vld_q || !timing_equal(sample, ref_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q     <= '0;
            ref_q      <= '0;
            cand_vld_q <= 1'b0;
            ref_vld_q  <= 1'b0;
            run_cnt_q  <= '0;
            locked_q   <= 1'b0;
            change_q   <= 1'b0;
        end else if (!sig_valid) begin
            cand_vld_q <= 1'b0;
            ref_vld_q  <= 1'b0;
            run_cnt_q  <= '0;
            locked_q   <= 1'b0;
            change_q   <= 1'b0;
        end else begin
            change_q <= 1'b0;
            if (frame_strobe) begin
                cand_q     <= sample;
                cand_vld_q <= 1'b1;
                run_cnt_q  <= cnt_next;
                locked_q   <= stable_now;
                if (new_change) begin
                    ref_q     <= sample;
                    ref_vld_q <= 1'b1;
                    change_q  <= 1'b1;
                end
            end
        end
    end

    assign locked_o = locked_q;
    assign change_o = change_q;

    AST_CHANGE_NEEDS_VALID_STROBE: assert property (@(posedge clk) disable iff (rst)
        change_o |-> $past(sig_valid && frame_strobe)); // R9
    AST_INVALID_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        !sig_valid |=> (!locked_o && !change_o)); // R8
    AST_INVALID_DROPS_REF: assert property (@(posedge clk) disable iff (rst)
        !sig_valid |=> !ref_vld_q); // R4

endmodule

// File: rtl/rcn_pulse_timer.sv
module rcn_pulse_timer
    import rcn_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy_o
);

    localparam int unsigned PRESCALE = CLK_HZ / 1000;
    localparam int          MS_W     = $clog2(PULSE_MS);

    logic            busy_q;
    logic [MS_W-1:0] ms_q;
    logic            tick;
    logic            last;

    generate
        if (PRESCALE <= 1) begin : g_no_pre
            assign tick = 1'b1;
        end else begin : g_pre
            localparam int PRE_W = $clog2(PRESCALE);
            logic [PRE_W-1:0] pre_q;
            assign tick = (pre_q == PRE_W'(PRESCALE - 1));
            always_ff @(posedge clk) begin
                if (rst || start || !busy_q || tick)
                    pre_q <= '0;
                else
                    pre_q <= pre_q + PRE_W'(1);
            end
        end
    endgenerate

    assign last = tick && (ms_q == MS_W'(PULSE_MS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ms_q   <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            ms_q   <= '0;
        end else if (busy_q) begin
            if (last) begin
                busy_q <= 1'b0;
                ms_q   <= '0;
            end else if (tick) begin
                ms_q <= ms_q + MS_W'(1);
            end
        end
    end

    assign busy_o = busy_q;

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_o); // R6
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !start && last) |=> !busy_o); // R2
    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start) |=> !busy_o); // R5

endmodule

// File: rtl/res_change_notifier.sv
module res_change_notifier
    import rcn_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int          CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_display,
    input  logic             sig_valid,
    input  logic             frame_strobe,
    input  logic [11:0]      h_active,
    input  logic [11:0]      v_active,
    input  logic [19:0]      frame_period,
    input  logic [CNT_W-1:0] stable_frames,
    output logic             status_pin
);

    vid_timing_t sample;
    logic        locked;
    logic        change;
    logic        busy;
    pin_mode_e   pin_mode;

    assign sample.h_act  = h_active;
    assign sample.v_act  = v_active;
    assign sample.period = frame_period;
    assign pin_mode      = pin_mode_e'(mode_display);

    rcn_stability_filter #(.CNT_W(CNT_W)) u_filter (
        .clk          (clk),
        .rst          (rst),
        .sig_valid    (sig_valid),
        .frame_strobe (frame_strobe),
        .sample       (sample),
        .need_frames  (stable_frames),
        .locked_o     (locked),
        .change_o     (change)
    );

    rcn_pulse_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (change),
        .busy_o (busy)
    );

    always_comb begin
        case (pin_mode)
            PIN_DISPLAY: status_pin = locked;
            default:     status_pin = busy;
        endcase
    end

    AST_RESET_PIN_LOW: assert property (@(posedge clk)
        rst |=> !status_pin); // R1
    AST_CHANGE_STARTS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (change && !mode_display) |=> (status_pin || mode_display)); // R2

endmodule

// File: tb/res_change_notifier_tb.sv
module res_change_notifier_tb_top;

    localparam int unsigned CLK_HZ = 2000;
    localparam int          CNT_W  = 4;
    localparam int          P      = (CLK_HZ / 1000) * 200;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_display = 1'b0;
    logic             sig_valid = 1'b0;
    logic             frame_strobe = 1'b0;
    logic [11:0]      h_active = '0;
    logic [11:0]      v_active = '0;
    logic [19:0]      frame_period = '0;
    logic [CNT_W-1:0] stable_frames = CNT_W'(3);
    logic             status_pin;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    res_change_notifier #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .mode_display(mode_display), .sig_valid(sig_valid),
        .frame_strobe(frame_strobe), .h_active(h_active), .v_active(v_active),
        .frame_period(frame_period), .stable_frames(stable_frames), .status_pin(status_pin)
    );

    // behavioural reference: history queue of frames plus a countdown
    logic [43:0] hist[$];
    logic [43:0] ref_t;
    bit          ref_ok = 0;
    bit          m_stable = 0;
    bit          chg_pend = 0;
    int          remain = 0;

    always @(posedge clk) begin
        bit          nchg;
        int          need;
        logic [43:0] cur;
        nchg = 0;
        cur  = {h_active, v_active, frame_period};
        need = (stable_frames == 0) ? 1 : int'(stable_frames);
        if (rst) begin
            hist.delete(); ref_ok = 0; m_stable = 0; remain = 0; chg_pend = 0;
        end else begin
            if (chg_pend) remain = P;
            else if (remain > 0) remain--;
            if (!sig_valid) begin
                hist.delete(); ref_ok = 0; m_stable = 0;
            end else if (frame_strobe) begin
                hist.push_back(cur);
                while (hist.size() > need) void'(hist.pop_front());
                m_stable = (hist.size() == need);
                foreach (hist[i]) if (hist[i] != cur) m_stable = 0;
                if (m_stable && (!ref_ok || ref_t != cur)) begin
                    ref_t = cur; ref_ok = 1; nchg = 1;
                end
            end
            chg_pend = nchg;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            bit exp_pin;
            exp_pin = mode_display ? m_stable : (remain > 0);
            check(status_pin === exp_pin, cur_req, "status_pin",
                  int'(status_pin), int'(exp_pin));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int h, input int v, input int p, input int gap);
        @(negedge clk);
        h_active = 12'(h); v_active = 12'(v); frame_period = 20'(p);
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        idle(gap);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int high_cnt;
        // R1: reset state
        cur_req = "R1";
        idle(4);
        check(status_pin === 1'b0, "R1", "pin in reset", int'(status_pin), 0);
        mode_display = 1'b1; idle(1);
        check(status_pin === 1'b0, "R1", "display pin in reset", int'(status_pin), 0);
        mode_display = 1'b0;
        rst = 1'b0; sig_valid = 1'b1; idle(2);

        // R3: two identical frames are not enough with stable_frames=3
        cur_req = "R3";
        frame(1920, 1080, 33000, 3);
        frame(1920, 1080, 33000, 3);
        check(status_pin === 1'b0, "R3", "no pulse before settle", int'(status_pin), 0);
        // R4 + R2: third frame settles, first lock is a change; measure length
        cur_req = "R2";
        frame(1920, 1080, 33000, 0);
        high_cnt = 0;
        for (int i = 0; i < P + 10; i++) begin
            @(negedge clk);
            if (status_pin) high_cnt++;
        end
        check(high_cnt == P, "R2", "pulse length", high_cnt, P);
        check(ref_ok == 1, "R4", "first lock registered", int'(ref_ok), 1);

        // R5: repeating reference timing gives no new pulse
        cur_req = "R5";
        for (int i = 0; i < 5; i++) frame(1920, 1080, 33000, 3);
        idle(5);

        // R3: a glitch frame then the old timing again is not a change
        frame(1280, 720, 16000, 3);
        for (int i = 0; i < 3; i++) frame(1920, 1080, 33000, 3);
        idle(5);

        // R6: change, then another change during the pulse restarts it
        cur_req = "R6";
        for (int i = 0; i < 3; i++) frame(3840, 2160, 66000, 3);
        idle(50);
        for (int i = 0; i < 3; i++) frame(1280, 720, 16000, 3);
        idle(P + 20);

        // R9: strobes with no valid signal do nothing
        cur_req = "R9";
        sig_valid = 1'b0;
        for (int i = 0; i < 4; i++) frame(800, 600, 12000, 2);
        idle(5);

        // R4: same timing after valid loss counts again as a change
        cur_req = "R4";
        sig_valid = 1'b1;
        for (int i = 0; i < 3; i++) frame(1280, 720, 16000, 3);
        idle(P + 10);

        // R10, R7, R8: display mode level
        cur_req = "R7";
        mode_display = 1'b1;
        sig_valid = 1'b0; idle(2);
        sig_valid = 1'b1;
        frame(1024, 768, 20000, 2);
        frame(1024, 768, 20000, 2);
        frame(1024, 768, 20000, 0);
        @(negedge clk);
        check(status_pin === 1'b1, "R7", "level after settle", int'(status_pin), 1);
        cur_req = "R8";
        frame(640, 480, 9000, 0);
        check(status_pin === 1'b0, "R8", "level drop on run break", int'(status_pin), 0);
        for (int i = 0; i < 3; i++) frame(640, 480, 9000, 2);
        check(status_pin === 1'b1, "R8", "level back after settle", int'(status_pin), 1);
        sig_valid = 1'b0;
        @(negedge clk);
        check(status_pin === 1'b0, "R8", "level drop on valid loss", int'(status_pin), 0);
        cur_req = "R10";
        sig_valid = 1'b1;
        for (int i = 0; i < 3; i++) frame(640, 480, 9000, 2);
        mode_display = 1'b0; idle(3);
        mode_display = 1'b1; idle(3);

        // R3: stable_frames of 0 acts as 1
        cur_req = "R3";
        mode_display = 1'b0;
        stable_frames = '0;
        frame(720, 576, 40000, 0);
        @(negedge clk);
        check(status_pin === 1'b1, "R3", "single-frame settle", int'(status_pin), 1);
        idle(P + 10);

        // R1: reset mid-pulse drives the pin low
        cur_req = "R1";
        stable_frames = CNT_W'(1);
        frame(1600, 900, 30000, 5);
        rst = 1'b1;
        @(negedge clk);
        check(status_pin === 1'b0, "R1", "pin after reset", int'(status_pin), 0);
        idle(3);
        finish_run();
    end

endmodule